// File: doc/BRIEF.md
# Register Rename Map Table

This block renames destination registers for one register class of an out-of-order core. It accepts one request per cycle. Each request carries an architectural destination index and a pinned-write count. The block answers with the physical tag now bound to that destination and the tag that was bound before the request. The previous tag is what a later commit stage frees.

The table holds one physical tag per architectural register. New tags come from an attached free list, which is a FIFO of unused tags. Every physical tag has two counters:

- a pinned-write counter, which lets several writes share one physical register before it is renamed again;
- a writes-to-complete counter.

There are three outcomes:

- **Zero register.** A configured zero register is never remapped.
- **Pinned reuse.** A destination whose current tag still has pinned writes pending keeps that tag, and only its pinned-write counter is decremented.
- **Fresh allocation.** Every other request takes a new tag from the free list.

When a fresh tag is needed but the free list is empty, the block stalls its request handshake.

Top module: `rename_map`

## Requirements
- R1: The `rsp_prev_o` field of every response is the tag held for the requested architectural register before that request was applied. After reset, architectural register i holds physical tag i.
- R2: A request whose index, zero-extended by one bit, equals `zero_idx_i` is a zero-register request. It reports kind 0, its new tag equals its previous tag, and it consumes no free tag. A `zero_idx_i` with its top bit set never matches.
- R3: When the previous tag's pinned counter is nonzero, the request reports kind 1. Its new tag equals the previous tag, the counter is decremented by one, and no free tag is consumed.
- R4: A kind-1 request that itself carries a nonzero pinned count sets `err_o`. `err_o` then stays high until reset. The request is still handled as a kind-1 reuse.
- R5: Every other request reports kind 2. It takes the next free tag and writes it into the table. Free tags are handed out in ascending order from NUM_ARCH up to NUM_PHYS-1.
- R6: On a kind-2 request, the new tag's pinned counter is loaded with the request count, and its writes-to-complete counter is loaded with that count plus one. `rsp_pin_o` and `rsp_wtc_o` report the new tag's counters after the update.
- R7: `req_ready_o` is low exactly when a kind-2 request is presented and no free tag is left. A stalled request changes nothing. Kind-0 and kind-1 requests are still accepted when the free list is empty.
- R8: `rsp_valid_o` is high for exactly the cycle after an accepted request and low otherwise. A request accepted in the very next cycle sees the table as updated by the previous request.
- R9: After reset, `rsp_valid_o` and `err_o` are low, and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| zero_idx_i | input | AW+1 | Zero-register index; top bit set means none |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_arch_i | input | AW | Architectural destination index |
| req_pin_i | input | PIN_W | Pinned-write count of the request |
| rsp_valid_o | output | 1 | Response valid |
| rsp_kind_o | output | 2 | 0 zero register, 1 pinned reuse, 2 fresh |
| rsp_new_o | output | PW | Newly bound physical tag |
| rsp_prev_o | output | PW | Previously bound physical tag |
| rsp_pin_o | output | PIN_W | Pinned counter of the new tag after update |
| rsp_wtc_o | output | PIN_W+1 | Writes-to-complete counter of the new tag |
| err_o | output | 1 | Sticky illegal-pinning flag |

## Verification
The bench sweeps every pinned count from 0 to 15 through a fresh allocation, then drains the count with back-to-back reuse requests until the register is renamed again. A design that decrements at the wrong time would return the wrong tag once the counter reaches zero. A design that pops the free list during a reuse would skip a tag.

Every zero-register index is tried, along with the never-matching index. A design that remaps the zero register, or that wrongly treats an index with the top bit set as a match, would return a fresh tag for it.

The free list is drained until it is empty. The stall must then hit only fresh requests, while zero-register and reuse requests still pass. The illegal pinned request must set an error that persists across later legal requests.

// File: rtl/rename_pkg.sv
package rename_pkg;
  typedef enum logic [1:0] {
    KIND_ZERO  = 2'd0,
    KIND_PIN   = 2'd1,
    KIND_FRESH = 2'd2
  } ren_kind_e;
endpackage

// File: rtl/rename_free_fifo.sv
// Free-tag list; preloaded at reset with NUM_ARCH..NUM_PHYS-1, pop only.
module rename_free_fifo #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int PW      = $clog2(NUM_PHYS),
  localparam int NFREE   = NUM_PHYS - NUM_ARCH,
  localparam int CW      = $clog2(NFREE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  output logic [PW-1:0] head_o,
  output logic          empty_o
);
  logic [CW-1:0] rd_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_cnt_q <= '0;
    else if (pop_i && !empty_o) rd_cnt_q <= rd_cnt_q + CW'(1);
  end

  assign empty_o = (rd_cnt_q == CW'(NFREE));
  assign head_o  = PW'(NUM_ARCH) + PW'(rd_cnt_q);
endmodule

// File: rtl/rename_map_array.sv
// Architectural-to-physical tag table, identity mapping at reset.
module rename_map_array #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int PW      = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_idx_i,
  output logic [PW-1:0] rd_tag_o,
  input  logic          we_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [PW-1:0] wr_tag_i
);
  logic [PW-1:0] tag_q [NUM_ARCH];

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            tag_q[g] <= PW'(g);
      else if (we_i && wr_idx_i == AW'(g))    tag_q[g] <= wr_tag_i;
    end
  end

  assign rd_tag_o = tag_q[rd_idx_i];
endmodule

// File: rtl/rename_pin_table.sv
// Per-physical-tag pinned-write and writes-to-complete counters.
module rename_pin_table #(
  parameter int NUM_PHYS = 16,
  parameter int PIN_W    = 4,
  localparam int PW      = $clog2(NUM_PHYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PW-1:0]    rd_tag_i,
  output logic [PIN_W-1:0] rd_pin_o,
  output logic [PIN_W:0]   rd_wtc_o,
  input  logic             ld_i,
  input  logic             dec_i,
  input  logic [PW-1:0]    wr_tag_i,
  input  logic [PIN_W-1:0] ld_pin_i
);
  logic [PIN_W-1:0] pin_q [NUM_PHYS];
  logic [PIN_W:0]   wtc_q [NUM_PHYS];

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_tag
    logic hit;
    assign hit = (wr_tag_i == PW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pin_q[g] <= '0;
        wtc_q[g] <= '0;
      end else if (hit && ld_i) begin
        pin_q[g] <= ld_pin_i;
        wtc_q[g] <= {1'b0, ld_pin_i} + (PIN_W+1)'(1);
      end else if (hit && dec_i && pin_q[g] != '0) begin
        pin_q[g] <= pin_q[g] - PIN_W'(1);  // saturates at zero
      end
    end
  end

  assign rd_pin_o = pin_q[rd_tag_i];
  assign rd_wtc_o = wtc_q[rd_tag_i];
endmodule

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int PIN_W    = 4,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int PW      = $clog2(NUM_PHYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW:0]      zero_idx_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_arch_i,
  input  logic [PIN_W-1:0] req_pin_i,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_kind_o,
  output logic [PW-1:0]    rsp_new_o,
  output logic [PW-1:0]    rsp_prev_o,
  output logic [PIN_W-1:0] rsp_pin_o,
  output logic [PIN_W:0]   rsp_wtc_o,
  output logic             err_o
);
  import rename_pkg::*;

  logic [PW-1:0]    prev_tag, free_head, new_tag;
  logic [PIN_W-1:0] prev_pin, new_pin;
  logic [PIN_W:0]   prev_wtc, new_wtc;
  logic             free_empty, is_zero, is_pinned, need_fresh, accept, illegal;
  ren_kind_e        kind;

  rename_map_array #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (req_arch_i),
    .rd_tag_o (prev_tag),
    .we_i     (accept && need_fresh),
    .wr_idx_i (req_arch_i),
    .wr_tag_i (free_head)
  );

  rename_free_fifo #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pop_i   (accept && need_fresh),
    .head_o  (free_head),
    .empty_o (free_empty)
  );

  rename_pin_table #(.NUM_PHYS(NUM_PHYS), .PIN_W(PIN_W)) u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_tag_i (prev_tag),
    .rd_pin_o (prev_pin),
    .rd_wtc_o (prev_wtc),
    .ld_i     (accept && need_fresh),
    .dec_i    (accept && kind == KIND_PIN),
    .wr_tag_i (need_fresh ? free_head : prev_tag),
    .ld_pin_i (req_pin_i)
  );

  // Zero register has priority over pinning.
  assign is_zero    = ({1'b0, req_arch_i} == zero_idx_i);
  assign is_pinned  = (prev_pin != '0);
  assign need_fresh = !is_zero && !is_pinned;
  assign req_ready_o = !(need_fresh && free_empty);
  assign accept     = req_valid_i && req_ready_o;
  assign illegal    = accept && !is_zero && is_pinned && (req_pin_i != '0);

  always_comb begin
    kind    = KIND_FRESH;
    new_tag = free_head;
    new_pin = req_pin_i;
    new_wtc = {1'b0, req_pin_i} + (PIN_W+1)'(1);
    if (is_zero) begin
      kind    = KIND_ZERO;
      new_tag = prev_tag;
      new_pin = prev_pin;
      new_wtc = prev_wtc;
    end else if (is_pinned) begin
      kind    = KIND_PIN;
      new_tag = prev_tag;
      new_pin = prev_pin - PIN_W'(1);
      new_wtc = prev_wtc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_kind_o  <= 2'd0;
      rsp_new_o   <= '0;
      rsp_prev_o  <= '0;
      rsp_pin_o   <= '0;
      rsp_wtc_o   <= '0;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_kind_o <= kind;
        rsp_new_o  <= new_tag;
        rsp_prev_o <= prev_tag;
        rsp_pin_o  <= new_pin;
        rsp_wtc_o  <= new_wtc;
      end
      if (illegal) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int PIN_W    = 4,
  localparam int PW      = $clog2(NUM_PHYS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic [1:0]       rsp_kind_o,
  input logic [PW-1:0]    rsp_new_o,
  input logic [PW-1:0]    rsp_prev_o,
  input logic [PIN_W-1:0] rsp_pin_o,
  input logic [PIN_W:0]   rsp_wtc_o,
  input logic             err_o
);
  assert_accept_resp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);
  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o);
  assert_zero_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd0) |-> rsp_new_o == rsp_prev_o);
  assert_pin_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd1) |-> rsp_new_o == rsp_prev_o);
  assert_fresh_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd2) |-> rsp_new_o >= PW'(NUM_ARCH));
  assert_fresh_cnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd2) |-> rsp_wtc_o == {1'b0, rsp_pin_o} + (PIN_W+1)'(1));
  assert_err_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind rename_map rename_map_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .PIN_W(PIN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_kind_o  (rsp_kind_o),
  .rsp_new_o   (rsp_new_o),
  .rsp_prev_o  (rsp_prev_o),
  .rsp_pin_o   (rsp_pin_o),
  .rsp_wtc_o   (rsp_wtc_o),
  .err_o       (err_o)
);

// File: tb/rename_map_test.sv
`timescale 1ns/1ps
module rename_map_test;
  localparam int NA = 8, NP = 16, PIN_W = 4;
  localparam int AW = 3, PW = 4;

  logic             clk_i = 0, rst_ni = 0;
  logic [AW:0]      zero_idx_i = '0;
  logic             req_valid_i = 0;
  logic             req_ready_o;
  logic [AW-1:0]    req_arch_i = '0;
  logic [PIN_W-1:0] req_pin_i = '0;
  logic             rsp_valid_o, err_o;
  logic [1:0]       rsp_kind_o;
  logic [PW-1:0]    rsp_new_o, rsp_prev_o;
  logic [PIN_W-1:0] rsp_pin_o;
  logic [PIN_W:0]   rsp_wtc_o;

  rename_map #(.NUM_ARCH(NA), .NUM_PHYS(NP), .PIN_W(PIN_W)) uut (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int map_m [NA];
  int pin_m [NP];
  int wtc_m [NP];
  int head_m, zid_m;
  bit err_m;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset(input int z);
    @(negedge clk_i);
    rst_ni = 0; req_valid_i = 0; zero_idx_i = (AW+1)'(z);
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int i = 0; i < NP; i++) begin pin_m[i] = 0; wtc_m[i] = 0; end
    head_m = NA; zid_m = z; err_m = 0;
    #1;
    chk(rsp_valid_o == 0, "R9 rsp_valid", int'(rsp_valid_o), 0);
    chk(err_o == 0, "R9 err", int'(err_o), 0);
    chk(req_ready_o == 1, "R9 ready", int'(req_ready_o), 1);
    @(negedge clk_i);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_req(input int a, input int p);
    int prev, kind, nt, np, nw;
    bit zero, pinned, fresh, stall;
    prev   = map_m[a];
    zero   = (a == zid_m);
    pinned = !zero && pin_m[prev] != 0;
    fresh  = !zero && !pinned;
    stall  = fresh && head_m == NP;
    req_valid_i = 1; req_arch_i = AW'(a); req_pin_i = PIN_W'(p);
    #1;
    chk(req_ready_o == !stall, "R7 ready", int'(req_ready_o), int'(!stall));
    if (stall) begin
      req_valid_i = 0;
      @(negedge clk_i);
      chk(rsp_valid_o == 0, "R7 stalled no response", int'(rsp_valid_o), 0);
      return;
    end
    if (zero) begin kind = 0; nt = prev; np = pin_m[prev]; nw = wtc_m[prev]; end
    else if (pinned) begin
      kind = 1; nt = prev; np = pin_m[prev] - 1; nw = wtc_m[prev];
      if (p != 0) err_m = 1;
    end else begin
      kind = 2; nt = head_m; np = p; nw = p + 1;
    end
    @(negedge clk_i);
    req_valid_i = 0;
    chk(rsp_valid_o == 1, "R8 rsp_valid", int'(rsp_valid_o), 1);
    chk(int'(rsp_prev_o) == prev, "R1 prev tag", int'(rsp_prev_o), prev);
    chk(int'(rsp_kind_o) == kind, "R2/R3/R5 kind", int'(rsp_kind_o), kind);
    chk(int'(rsp_new_o) == nt, "R5 new tag", int'(rsp_new_o), nt);
    chk(int'(rsp_pin_o) == np, "R6 pin count", int'(rsp_pin_o), np);
    chk(int'(rsp_wtc_o) == nw, "R6 wtc count", int'(rsp_wtc_o), nw);
    chk(err_o == err_m, "R4 err", int'(err_o), int'(err_m));
    pin_m[nt] = np; wtc_m[nt] = nw;
    if (fresh) begin map_m[a] = nt; head_m++; end
  endtask

  initial begin
    // R1/R5: identity map, ascending pops, zero reg at 0 (R2)
    do_reset(0);
    for (int a = 0; a < NA; a++) do_req(a, 0);
    do_req(3, 2);                 // last free tag, R6
    do_req(3, 0); do_req(3, 0);   // R3 back-to-back reuse, R8
    do_req(5, 0);                 // R7 stall, list empty
    do_req(0, 0);                 // R2 zero accepted while empty
    do_req(3, 0);                 // R7 stall: counter drained
    @(negedge clk_i);
    chk(rsp_valid_o == 0, "R8 idle no response", int'(rsp_valid_o), 1'b0);
    // R4: illegal pinning sets sticky error
    do_reset(15);
    do_req(0, 3); do_req(0, 1); do_req(1, 0); do_req(0, 0);
    // R2: every zero index, plus never-matching index 8
    for (int z = 0; z <= NA; z++) begin
      do_reset(z);
      do_req(z % NA, 0); do_req((z + 1) % NA, 0); do_req(z % NA, 0);
    end
    // R3/R6: sweep all pin counts
    for (int p = 0; p < 16; p++) begin
      do_reset(15);
      do_req(2, p);
      for (int k = 0; k < p; k++) do_req(2, 0);
      do_req(2, 0);
      do_req(2, 1);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule